// File: doc/BRIEF.md
# Streaming 1-D Convolution Layer

This block computes one layer of a quantized 1-D convolutional network on a stream of samples. All input channels arrive together as one beat on a single valid/ready input. Every channel keeps a sliding window of the most recent kernel-length samples. Each output channel multiplies every window entry by its own signed 8-bit weight, adds the products first within each input channel and then across all input channels, and adds a per-output bias. The result goes through a ReLU, an arithmetic right shift by a fixed per-layer amount and a symmetric clamp. This produces one signed 8-bit value per output channel, delivered on a valid/ready output. Weights, biases, the padding length and the shift amount are parameters fixed at build time.

A frame is a run of input beats that ends with `in_last`. Before the first sample of each frame, the block shifts PAD zero samples into every window. It spends one clock per zero and holds `in_ready` low while it does so. An output is produced only when the window holds K samples that belong to the current frame, counting padding as part of the frame. The output that belongs to a frame's final input sample carries `out_last`. Back-pressure works as a global stall. While `out_valid` is high and `out_ready` is low, the whole pipeline freezes, including the windows and the padding counter. During the stall `in_ready` is low and the output beat holds steady. `in_ready` therefore depends combinationally on `out_ready`. A beat moves on either side only on a clock edge at which both its valid and its ready are high.

Top module: `conv1d_stream`

## Requirements
- R1: For output channel o, the value before activation is bias[o] plus the sum over channels c and taps k = 0..K-1 of w[o][c][k] times the k-th oldest sample in channel c's window (k = 0 is the oldest). Weight (o,c,k) sits at bits ((o*C_IN+c)*K+k)*8 of `WEIGHTS`, and bias o sits at bits o*BIAS_W of `BIASES`.
- R2: A value before activation that is zero or negative produces an output of 0.
- R3: A positive value is arithmetically shifted right by SHIFT and then clamped to at most +127. No output ever has its sign bit set.
- R4: PAD zero samples enter every window before the first sample of a frame. During those PAD clocks `in_ready` is low. This applies after reset and after every accepted `in_last`.
- R5: A frame of L samples yields exactly L+PAD-K+1 outputs. The last of them, and only that one, has `out_last` high. Frames must satisfy L+PAD >= K.
- R6: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_valid` hold and `in_ready` is low. No beat is lost or repeated.
- R7: With `out_ready` held high, the output for the window completed by a sample accepted at clock edge e becomes visible after edge e+LAT, where LAT = 1 + clog2(K) + clog2(C_IN) + 2.
- R8: During and right after reset, `out_valid` is low.
- R9: Idle cycles between input beats (`in_valid` low) do not change any output value or its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts an input beat |
| in_data | input | C_IN*8 | One signed 8-bit sample per input channel |
| in_last | input | 1 | Beat is the final sample of its frame |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts an output beat |
| out_data | output | C_OUT*8 | One signed 8-bit result per output channel |
| out_last | output | 1 | Beat is the final output of its frame |

## Verification
Two events can land on the same clock. One is the frame boundary: an accepted `in_last` that starts the next frame's zero padding. The other is a downstream stall that freezes the pipeline. The bench provokes this with back-to-back frames, including a frame of minimum length, while `out_ready` follows a periodic on/off pattern and `in_valid` has gaps. It judges the result against a behavioural model of the padded correlation, bias, ReLU, shift and clamp. Every output value and every `out_last` position must match the model. Each stalled beat must also be held unchanged into the following cycle, with `in_ready` low.

// File: rtl/conv1d_pkg.sv
package conv1d_pkg;
  localparam int unsigned SAMPLE_W = 8;
  localparam int signed SAT_LIMIT = 127;

  // accumulator wide enough for K*C products of two signed 8-bit values
  function automatic int unsigned acc_width(input int unsigned k, input int unsigned ch);
    return 2 * SAMPLE_W + $clog2(k * ch) + 1;
  endfunction

  // symmetric saturation to [-127, +127]; input must fit 32 bits
  function automatic logic [SAMPLE_W-1:0] clamp_sym(input logic signed [31:0] v);
    if (v > SAT_LIMIT) return SAMPLE_W'(SAT_LIMIT);
    if (v < -SAT_LIMIT) return SAMPLE_W'(-SAT_LIMIT);
    return v[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/conv1d_window.sv
module conv1d_window #(
  parameter int unsigned K  = 5,
  parameter int unsigned DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift,
  input  logic [DW-1:0]         din,
  output logic [K-1:0][DW-1:0]  taps
);
  // taps[0] is the newest sample, taps[K-1] the oldest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (shift) begin
      taps[0] <= din;
      for (int i = 1; i < int'(K); i++) taps[i] <= taps[i-1];
    end
  end
endmodule

// File: rtl/conv1d_adder_tree.sv
module conv1d_adder_tree #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 16,
  parameter int unsigned OW = 22
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic [N-1:0][IW-1:0] in_vec,
  output logic signed [OW-1:0] sum
);
  localparam int unsigned LV = $clog2(N);
  localparam int unsigned W2 = 1 << LV;

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    logic signed [OW-1:0] node [W2 >> l];
    if (l == 0) begin : g_leaf
      always_comb begin
        for (int i = 0; i < int'(W2); i++) node[i] = '0;
        for (int i = 0; i < int'(N); i++) node[i] = OW'($signed(in_vec[i]));
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        if (en) begin
          for (int i = 0; i < int'(W2 >> l); i++)
            node[i] <= g_lv[l-1].node[2*i] + g_lv[l-1].node[2*i+1];
        end
      end
    end
  end

  assign sum = g_lv[LV].node[0];
endmodule

// File: rtl/conv1d_chan_unit.sv
module conv1d_chan_unit #(
  parameter int unsigned K  = 5,
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 22
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic [K-1:0][DW-1:0] taps,
  input  logic [K*DW-1:0]      wts,
  output logic signed [AW-1:0] sum
);
  logic signed [2*DW-1:0]      prod [K];
  logic [K-1:0][2*DW-1:0]      prod_vec;

  // registered multipliers; weight k meets the k-th oldest sample
  always_ff @(posedge clk) begin
    if (en) begin
      for (int k = 0; k < int'(K); k++)
        prod[k] <= $signed(taps[K-1-k]) * $signed(wts[k*DW +: DW]);
    end
  end

  always_comb begin
    for (int k = 0; k < int'(K); k++) prod_vec[k] = prod[k];
  end

  conv1d_adder_tree #(.N(K), .IW(2*DW), .OW(AW)) u_tree (
    .clk    (clk),
    .en     (en),
    .in_vec (prod_vec),
    .sum    (sum)
  );
endmodule

// File: rtl/conv1d_post.sv
module conv1d_post #(
  parameter int unsigned AW    = 22,
  parameter int unsigned BW    = 16,
  parameter int unsigned SHIFT = 6
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic signed [AW-1:0] acc,
  input  logic [BW-1:0]        bias,
  output logic [7:0]           q
);
  logic signed [AW:0] biased;
  logic signed [AW:0] relu_q;
  logic signed [AW:0] shifted;

  always_comb begin
    biased  = (AW+1)'(acc) + (AW+1)'($signed(bias));
    shifted = relu_q >>> SHIFT;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      relu_q <= (biased > 0) ? biased : '0;
      q      <= conv1d_pkg::clamp_sym(32'(shifted));
    end
  end
endmodule

// File: rtl/conv1d_stream.sv
module conv1d_stream #(
  parameter int unsigned C_IN   = 4,
  parameter int unsigned C_OUT  = 4,
  parameter int unsigned K      = 5,
  parameter int unsigned PAD    = 2,
  parameter int unsigned SHIFT  = 6,
  parameter int unsigned BIAS_W = 16,
  parameter logic [C_OUT*C_IN*K*8-1:0] WEIGHTS = {(C_OUT*C_IN*K){8'h01}},
  parameter logic [C_OUT*BIAS_W-1:0]   BIASES  = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [C_IN-1:0][7:0]  in_data,
  input  logic                  in_last,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [C_OUT-1:0][7:0] out_data,
  output logic                  out_last
);
  localparam int unsigned SW  = conv1d_pkg::SAMPLE_W;
  localparam int unsigned AW  = conv1d_pkg::acc_width(K, C_IN);
  localparam int unsigned LAT = 1 + $clog2(K) + $clog2(C_IN) + 2;
  localparam int unsigned PCW = $clog2(PAD + 2);
  localparam int unsigned FW  = $clog2(K) + 1;

  logic           en;
  logic           padding;
  logic           accept;
  logic           shift;
  logic [PCW-1:0] pad_cnt;
  logic [FW-1:0]  fill;
  logic [LAT:0]   vpipe;
  logic [LAT:0]   lpipe;
  logic [C_IN-1:0][SW-1:0] sample;

  // global stall: nothing moves while a finished beat waits downstream
  assign en        = !vpipe[LAT] || out_ready;
  assign padding   = (pad_cnt != '0);
  assign in_ready  = en && !padding;
  assign accept    = in_valid && in_ready;
  assign shift     = en && (padding || in_valid);
  assign out_valid = vpipe[LAT];
  assign out_last  = lpipe[LAT];

  always_comb begin
    for (int c = 0; c < int'(C_IN); c++) sample[c] = padding ? '0 : in_data[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_cnt <= PCW'(PAD);
      fill    <= '0;
      vpipe   <= '0;
      lpipe   <= '0;
    end else if (en) begin
      vpipe <= {vpipe[LAT-1:0], shift && (fill >= FW'(K-1))};
      lpipe <= {lpipe[LAT-1:0], accept && in_last};
      if (padding) pad_cnt <= pad_cnt - 1'b1;
      if (accept && in_last) begin
        pad_cnt <= PCW'(PAD);
        fill    <= '0;
      end else if (shift && fill < FW'(K-1)) begin
        fill <= fill + 1'b1;
      end
    end
  end

  logic [C_IN-1:0][K-1:0][SW-1:0] taps;

  for (genvar c = 0; c < C_IN; c++) begin : g_win
    conv1d_window #(.K(K), .DW(SW)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (shift),
      .din   (sample[c]),
      .taps  (taps[c])
    );
  end

  for (genvar o = 0; o < C_OUT; o++) begin : g_out
    logic [C_IN-1:0][AW-1:0] csum;
    logic signed [AW-1:0]    total;

    for (genvar c = 0; c < C_IN; c++) begin : g_ch
      conv1d_chan_unit #(.K(K), .DW(SW), .AW(AW)) u_cu (
        .clk  (clk),
        .en   (en),
        .taps (taps[c]),
        .wts  (WEIGHTS[((o*C_IN + c)*K)*SW +: K*SW]),
        .sum  (csum[c])
      );
    end

    conv1d_adder_tree #(.N(C_IN), .IW(AW), .OW(AW)) u_sum (
      .clk    (clk),
      .en     (en),
      .in_vec (csum),
      .sum    (total)
    );

    conv1d_post #(.AW(AW), .BW(BIAS_W), .SHIFT(SHIFT)) u_post (
      .clk  (clk),
      .en   (en),
      .acc  (total),
      .bias (BIASES[o*BIAS_W +: BIAS_W]),
      .q    (out_data[o])
    );
  end
endmodule

// File: rtl/conv1d_stream_chk.sv
module conv1d_stream_chk #(
  parameter int unsigned C_OUT = 4,
  parameter int unsigned PAD   = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  in_last,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [C_OUT-1:0][7:0] out_data,
  input logic                  out_last
);
  p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_no_intake_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_last_has_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_idle_after_reset_r8: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  for (genvar o = 0; o < C_OUT; o++) begin : g_rng
    p_out_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_data[o][7]);
  end

  if (PAD > 0) begin : g_pad
    p_pad_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_last |=> !in_ready);
  end
endmodule

bind conv1d_stream conv1d_stream_chk #(.C_OUT(C_OUT), .PAD(PAD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/conv1d_stream_tb.sv
module conv1d_stream_tb;
  localparam int CI  = 3;
  localparam int CO  = 2;
  localparam int K   = 5;
  localparam int P   = 2;
  localparam int SH  = 4;
  localparam int BW  = 16;
  localparam int LAT = 1 + 3 + 2 + 2;

  function automatic int wv(int o, int c, int k);
    if (o == 0) return ((c + k) % 4) + 1;
    return ((c * 2 + k * 3) % 7) - 4;
  endfunction

  function automatic int bv(int o);
    return (o == 0) ? 3 : -5;
  endfunction

  function automatic logic [CO*CI*K*8-1:0] mk_w();
    logic [CO*CI*K*8-1:0] r = '0;
    for (int o = 0; o < CO; o++)
      for (int c = 0; c < CI; c++)
        for (int k = 0; k < K; k++)
          r[((o*CI + c)*K + k)*8 +: 8] = 8'(wv(o, c, k));
    return r;
  endfunction

  function automatic logic [CO*BW-1:0] mk_b();
    logic [CO*BW-1:0] r = '0;
    for (int o = 0; o < CO; o++) r[o*BW +: BW] = BW'(bv(o));
    return r;
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [CI-1:0][7:0] in_data = '0;
  logic in_last = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [CO-1:0][7:0] out_data;
  logic out_last;

  always #10 clk = ~clk;

  conv1d_stream #(
    .C_IN(CI), .C_OUT(CO), .K(K), .PAD(P), .SHIFT(SH), .BIAS_W(BW),
    .WEIGHTS(mk_w()), .BIASES(mk_b())
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int sd [0:511][0:CI-1];
  bit sl [0:511];
  int n_in;
  int ed [0:511][0:CO-1];
  bit el [0:511];
  int n_exp;
  int lat_in_it, lat_out_it;

  task automatic check(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic bit pat(int mode, int it);
    case (mode)
      1: return ((it * 7 + 3) % 5 != 0) && (it % 11 != 4);
      2: return ((it / 3) % 2) == 0;
      3: return (it % 4) != 3;
      default: return 1'b1;
    endcase
  endfunction

  task automatic clear_streams();
    n_in = 0;
    n_exp = 0;
  endtask

  // append a frame and its expected outputs (behavioural model)
  task automatic add_frame(int len, int kind, int seed);
    int start = n_in;
    for (int l = 0; l < len; l++) begin
      for (int c = 0; c < CI; c++) begin
        case (kind)
          1: sd[n_in][c] = 127;
          2: sd[n_in][c] = -127;
          default: sd[n_in][c] = ((l * 37 + c * 11 + seed * 5) % 255) - 127;
        endcase
      end
      sl[n_in] = (l == len - 1);
      n_in++;
    end
    for (int j = 0; j <= len + P - K; j++) begin
      for (int o = 0; o < CO; o++) begin
        int acc = bv(o);
        for (int c = 0; c < CI; c++)
          for (int k = 0; k < K; k++) begin
            int pos = j + k;
            int x = (pos < P) ? 0 : sd[start + pos - P][c];
            acc += x * wv(o, c, k);
          end
        if (acc < 0) acc = 0;
        acc = acc >>> SH;
        if (acc > 127) acc = 127;
        ed[n_exp][o] = acc;
      end
      el[n_exp] = (j == len + P - K);
      n_exp++;
    end
  endtask

  // drive the stored stream and compare every output beat
  task automatic run_stream(int vmode, int rmode, string req);
    int in_idx = 0;
    int out_idx = 0;
    int it = 0;
    bit prev_stall = 1'b0;
    logic [CO-1:0][7:0] prev_data = '0;
    while (out_idx < n_exp && it < 5000) begin
      @(negedge clk);
      in_valid  = (in_idx < n_in) && pat(vmode, it);
      out_ready = pat(rmode, it);
      if (in_idx < n_in) begin
        for (int c = 0; c < CI; c++) in_data[c] = 8'(sd[in_idx][c]);
        in_last = sl[in_idx];
      end else begin
        in_data = '0;
        in_last = 1'b0;
      end
      #1;
      if (prev_stall) begin
        check(out_valid === 1'b1, "R6 hold valid", int'(out_valid), 1);
        check(out_data === prev_data, "R6 hold data", int'(out_data), int'(prev_data));
      end
      if (out_valid && !out_ready)
        check(in_ready === 1'b0, "R6 intake blocked", int'(in_ready), 0);
      if (in_valid && in_ready) begin
        if (in_last) lat_in_it = it;
        in_idx++;
      end
      if (out_valid && out_ready) begin
        for (int o = 0; o < CO; o++)
          check($signed(out_data[o]) == ed[out_idx][o], req,
                int'($signed(out_data[o])), ed[out_idx][o]);
        check(out_last == el[out_idx], "R5 last flag", int'(out_last), int'(el[out_idx]));
        if (out_last) lat_out_it = it;
        out_idx++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      it++;
    end
    check(out_idx == n_exp, "R5 output count", out_idx, n_exp);
    check(in_idx == n_in, "R5 input count", in_idx, n_in);
    @(negedge clk);
    in_valid  = 1'b0;
    in_last   = 1'b0;
    out_ready = 1'b1;
    begin
      int extra = 0;
      for (int i = 0; i < LAT + 4; i++) begin
        @(negedge clk);
        #1;
        if (out_valid) extra++;
      end
      check(extra == 0, "R5 no extra outputs", extra, 0);
    end
  endtask

  task automatic t_reset();
    int cnt = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R8 valid low in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    #1;
    while (in_ready !== 1'b1 && cnt < 20) begin
      cnt++;
      @(negedge clk);
      #1;
    end
    check(cnt == P, "R4 padding cycles after reset", cnt, P);
    check(out_valid === 1'b0, "R8 valid low after reset", int'(out_valid), 0);
  endtask

  task automatic t_basic();
    clear_streams();
    add_frame(14, 0, 1);
    run_stream(0, 0, "R1 correlation");
    check(lat_out_it - lat_in_it == LAT + 1, "R7 latency", lat_out_it - lat_in_it, LAT + 1);
  endtask

  task automatic t_relu_sat();
    clear_streams();
    add_frame(8, 1, 0);
    add_frame(8, 2, 0);
    run_stream(0, 0, "R2_R3 relu and clamp");
    check(ed[0][0] == 127 && ed[0][1] == 0, "R3 model covers clamp", ed[0][0], 127);
  endtask

  task automatic t_bubbles();
    clear_streams();
    add_frame(11, 0, 3);
    add_frame(9, 0, 7);
    run_stream(1, 0, "R9 input gaps");
  endtask

  task automatic t_backpressure();
    clear_streams();
    add_frame(10, 0, 4);
    add_frame(K - P, 0, 5);
    add_frame(12, 0, 9);
    run_stream(3, 2, "R6 stalled stream");
  endtask

  task automatic t_short();
    clear_streams();
    add_frame(K - P, 0, 2);
    run_stream(0, 2, "R5 minimum frame");
    check(n_exp == 1, "R5 single output", n_exp, 1);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_relu_sat();
    t_bubbles();
    t_backpressure();
    t_short();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule